// File: doc/BRIEF.md
# Dual-Channel Interrupt Status Mirror

This block holds the interrupt state of a two-channel disk controller inside its configuration space. Each channel raises a level-sensitive interrupt request. The block latches that request as a pending bit and shows the bit at two configuration locations. One is a combined mode register that also holds the per-channel block (mask) bits. The other is a per-channel legacy register kept for older drivers. Software acknowledges a channel by writing a one to its pending bit at either location. Both views then read back cleared.

A single registered interrupt line is raised while any channel has an unblocked pending bit. A read-only enable register reports which channels are switched on. Channel 0 is always enabled. Channel 1 is enabled by a build parameter. Software reaches all of this through a dword-wide configuration port with byte enables. The port returns registered read data.

Top module: `irq_mirror_ctrl`

## Requirements
- R1: After reset, both pending bits and both block bits are 0 and `irq_out` is 0. The enable byte at 0x51 reads 0x04, or 0x0C when `SECOND_ON` is 1. Writes to 0x51 do not change it.
- R2: A rising edge on `irq_lvl[c]` sets channel c's pending bit on that clock edge. A falling edge clears it on that clock edge. A level that stays steady changes nothing.
- R3: Channel 0 pending reads at bit 2 of byte 0x71 and at bit 2 of byte 0x50. Channel 1 pending reads at bit 3 of byte 0x71 and at bit 4 of byte 0x57. The two views of a channel always read the same value.
- R4: Writing 1 to any pending bit position (0x50 bit 2, 0x57 bit 4, 0x71 bit 2 or bit 3) clears that channel's pending bit in both views. Writing 0 has no effect. No write can set a pending bit.
- R5: When a rising edge of a channel's level and a clearing write for that channel fall on the same clock edge, the pending bit ends up set.
- R6: Bits 4 and 5 of byte 0x71 are the block bits for channels 0 and 1. They are written directly and read back. Every other bit of bytes 0x50, 0x57 and 0x71 reads 0, and so does every other byte address.
- R7: `irq_out` equals (pend0 AND NOT blk0) OR (pend1 AND NOT blk1), evaluated on the state one clock earlier.
- R8: A byte lane whose enable in `cfg_be` is 0 is not written. Lane b carries byte address 4*`cfg_dw`+b in `cfg_wdata[8b+7:8b]`.
- R9: `cfg_rdata` is registered. It shows, one clock after `cfg_dw` is presented, the dword at that address as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | ADDR_W-2 (6) | Dword address for read and write |
| cfg_be | input | DATA_W/8 (4) | Byte enables for the write |
| cfg_wdata | input | DATA_W (32) | Write data |
| irq_lvl | input | 2 | Interrupt request level per channel (bit 0 = channel 0) |
| cfg_rdata | output | DATA_W (32) | Registered read data |
| irq_out | output | 1 | Registered combined interrupt line |

## Verification
The edge properties compare each `irq_lvl` bit with its value one clock earlier. They therefore assume the request levels are held low throughout reset, so that the first cycle after reset sees no edge that the design's own history register missed. The bench drives `irq_lvl` to 0 before every reset and changes it only after reset is released. It also changes levels and the write strobe only at falling clock edges, so each edge or clear lands on exactly one rising edge.

// File: rtl/irqmir_pkg.sv
package irqmir_pkg;

  localparam int NCH = 2;

  // byte addresses whose meaning other logic decodes
  localparam logic [7:0] ADR_ENAB = 8'h51;
  localparam logic [7:0] ADR_MODE = 8'h71;

  // legacy mirror location per channel
  function automatic logic [7:0] leg_addr(input int c);
    return (c == 0) ? 8'h50 : 8'h57;
  endfunction

  function automatic int leg_bit(input int c);
    return (c == 0) ? 2 : 4;
  endfunction

  // positions inside the mode byte
  function automatic int mode_pend_bit(input int c);
    return 2 + c;
  endfunction

  function automatic int mode_blk_bit(input int c);
    return 4 + c;
  endfunction

endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic clr,
  output logic pend
);
  logic lvl_q;
  logic rise, fall;

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (rise)
        pend <= 1'b1;          // hardware set beats a same-cycle clear
      else if (fall || clr)
        pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cfg_decode.sv
module irq_cfg_decode
  import irqmir_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int NBYTE = DATA_W / 8,
  localparam int LW    = $clog2(NBYTE),
  localparam int DW_W  = ADDR_W - LW
) (
  input  logic              wr,
  input  logic [DW_W-1:0]   dw,
  input  logic [NBYTE-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [NCH-1:0]    clr,
  output logic [NCH-1:0]    blk_we,
  output logic [NCH-1:0]    blk_val
);
  logic [ADDR_W-1:0] ba;
  logic [7:0]        bv;

  always_comb begin
    clr     = '0;
    blk_we  = '0;
    blk_val = '0;
    ba      = '0;
    bv      = '0;
    if (wr) begin
      for (int b = 0; b < NBYTE; b++) begin
        ba = {dw, LW'(b)};
        bv = wdata[8*b +: 8];
        if (be[b]) begin
          for (int c = 0; c < NCH; c++) begin
            if (ba == ADDR_W'(leg_addr(c)) && bv[leg_bit(c)])
              clr[c] = 1'b1;
            if (ba == ADDR_W'(ADR_MODE)) begin
              if (bv[mode_pend_bit(c)])
                clr[c] = 1'b1;
              blk_we[c]  = 1'b1;
              blk_val[c] = bv[mode_blk_bit(c)];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_cfg_readback.sv
module irq_cfg_readback
  import irqmir_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [7:0] ENAB_VAL = 8'h04,
  localparam int NBYTE = DATA_W / 8,
  localparam int LW    = $clog2(NBYTE),
  localparam int DW_W  = ADDR_W - LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW_W-1:0]   dw,
  input  logic [NCH-1:0]    pend,
  input  logic [NCH-1:0]    blk,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] view;
  logic [ADDR_W-1:0] ba;
  logic [7:0]        bv;

  always_comb begin
    view = '0;
    ba   = '0;
    bv   = '0;
    for (int b = 0; b < NBYTE; b++) begin
      ba = {dw, LW'(b)};
      bv = '0;
      if (ba == ADDR_W'(ADR_ENAB))
        bv = ENAB_VAL;
      for (int c = 0; c < NCH; c++) begin
        if (ba == ADDR_W'(leg_addr(c)))
          bv[leg_bit(c)] = pend[c];
        if (ba == ADDR_W'(ADR_MODE)) begin
          bv[mode_pend_bit(c)] = pend[c];
          bv[mode_blk_bit(c)]  = blk[c];
        end
      end
      view[8*b +: 8] = bv;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= view;
  end
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pend,
  input  logic [NCH-1:0] blk,
  output logic           irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend & ~blk);
  end
endmodule

// File: rtl/irq_mirror_ctrl.sv
module irq_mirror_ctrl
  import irqmir_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter bit SECOND_ON = 1'b0,
  localparam int NBYTE = DATA_W / 8,
  localparam int LW    = $clog2(NBYTE),
  localparam int DW_W  = ADDR_W - LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [DW_W-1:0]   cfg_dw,
  input  logic [NBYTE-1:0]  cfg_be,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [NCH-1:0]    irq_lvl,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              irq_out
);
  localparam logic [7:0] ENAB_VAL = SECOND_ON ? 8'h0C : 8'h04;

  logic [NCH-1:0] clr, blk_we, blk_val;
  logic [NCH-1:0] pend, blk;

  irq_cfg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr(cfg_wr), .dw(cfg_dw), .be(cfg_be), .wdata(cfg_wdata),
    .clr(clr), .blk_we(blk_we), .blk_val(blk_val)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    irq_pend_cell u_cell (
      .clk(clk), .rst(rst), .lvl(irq_lvl[c]), .clr(clr[c]), .pend(pend[c])
    );

    always_ff @(posedge clk) begin
      if (rst)            blk[c] <= 1'b0;
      else if (blk_we[c]) blk[c] <= blk_val[c];
    end
  end

  irq_cfg_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENAB_VAL(ENAB_VAL)) u_rd (
    .clk(clk), .rst(rst), .dw(cfg_dw), .pend(pend), .blk(blk), .rdata(cfg_rdata)
  );

  irq_line_gen #(.NCH(NCH)) u_line (
    .clk(clk), .rst(rst), .pend(pend), .blk(blk), .irq(irq_out)
  );
endmodule

// File: rtl/irqmir_chk.sv
module irqmir_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] irq_lvl,
  input logic [1:0] pend,
  input logic [1:0] blk,
  input logic       irq_out
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    // R5: a rising level always leaves the bit set, clear or not
    p_rise_sets_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_lvl[c]) |=> pend[c]);

    // R2: a falling level clears the bit
    p_fall_clears_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(irq_lvl[c]) |=> !pend[c]);

    // R4: nothing but a rising level sets the bit
    p_no_write_set_r4: assert property (@(posedge clk) disable iff (rst)
      (!pend[c] && !$rose(irq_lvl[c])) |=> !pend[c]);
  end

  // R7: the line follows unblocked pending state one clock later
  p_line_follows_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(pend & ~blk))));
endmodule

bind irq_mirror_ctrl irqmir_chk u_chk (
  .clk(clk), .rst(rst), .irq_lvl(irq_lvl), .pend(pend), .blk(blk), .irq_out(irq_out)
);

// File: tb/tb_irq_mirror_ctrl.sv
module tb_irq_mirror_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  irq_lvl = '0;
  logic [31:0] cfg_rdata;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_mirror_ctrl dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .irq_lvl(irq_lvl), .cfg_rdata(cfg_rdata), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [1:0]  lvl;
    logic        wr;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [1:0]  pend;
    logic [1:0]  blk;
    logic        irq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 1'b0, 8'h00, 4'h0, 32'h0000_0000, 2'b01, 2'b00, 1'b1}, // R2 ch0 rise
    '{2'b11, 1'b0, 8'h00, 4'h0, 32'h0000_0000, 2'b11, 2'b00, 1'b1}, // R2 ch1 rise
    '{2'b11, 1'b1, 8'h70, 4'h2, 32'h0000_0400, 2'b10, 2'b00, 1'b1}, // R4 clear ch0 via 0x71
    '{2'b11, 1'b1, 8'h54, 4'h8, 32'h1000_0000, 2'b00, 2'b00, 1'b0}, // R4 clear ch1 via 0x57
    '{2'b11, 1'b1, 8'h70, 4'h2, 32'h0000_3C00, 2'b00, 2'b11, 1'b0}, // R6 block, R4 no set
    '{2'b00, 1'b0, 8'h00, 4'h0, 32'h0000_0000, 2'b00, 2'b11, 1'b0}, // R2 fall
    '{2'b01, 1'b0, 8'h00, 4'h0, 32'h0000_0000, 2'b01, 2'b11, 1'b0}, // R7 masked
    '{2'b01, 1'b1, 8'h70, 4'h2, 32'h0000_2000, 2'b01, 2'b10, 1'b1}, // R7 unmask ch0
    '{2'b01, 1'b1, 8'h50, 4'h1, 32'hFFFF_FF04, 2'b00, 2'b10, 1'b0}, // R4 clear ch0 via 0x50
    '{2'b01, 1'b1, 8'h50, 4'h3, 32'h0000_FF00, 2'b00, 2'b10, 1'b0}, // R1 0x51 read-only
    '{2'b01, 1'b1, 8'h70, 4'hD, 32'h0000_FF00, 2'b00, 2'b10, 1'b0}, // R8 lane off
    '{2'b11, 1'b1, 8'h70, 4'h2, 32'h0000_2C00, 2'b10, 2'b10, 1'b0}, // R5 set wins
    '{2'b11, 1'b1, 8'h70, 4'h2, 32'h0000_0000, 2'b10, 2'b00, 1'b1}  // R4 zero write, R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_dw = a[7:2];
    @(posedge clk);
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic check_state(input string req, input logic [1:0] p, input logic [1:0] b,
                             input logic irq);
    logic [31:0] v;
    rd(8'h50, v);
    check({req, " R3 0x50 view"}, v, {16'h0, 8'h04, 5'b0, p[0], 2'b0});
    rd(8'h54, v);
    check({req, " R3 0x57 view"}, v, {3'b0, p[1], 4'b0, 24'h0});
    rd(8'h70, v);
    check({req, " R6 0x71 view"}, v, {16'h0, 2'b0, b, p, 2'b0, 8'h0});
    check({req, " R7 irq_out"}, {31'h0, irq_out}, {31'h0, irq});
  endtask

  task automatic do_reset();
    @(negedge clk);
    irq_lvl = 2'b00;
    cfg_wr  = 1'b0;
    rst     = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    do_reset();
    // R1: reset state
    check_state("R1 reset", 2'b00, 2'b00, 1'b0);
    // R6/R9: unmapped dwords read zero
    rd(8'h00, v);
    check("R6 unmapped 0x00", v, 32'h0);
    rd(8'h74, v);
    check("R6 unmapped 0x74", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      irq_lvl   = VEC[i].lvl;
      cfg_wr    = VEC[i].wr;
      cfg_dw    = VEC[i].addr[7:2];
      cfg_be    = VEC[i].be;
      cfg_wdata = VEC[i].data;
      @(posedge clk);
      @(negedge clk);
      cfg_wr = 1'b0;
      @(posedge clk);
      check_state($sformatf("step %0d", i), VEC[i].pend, VEC[i].blk, VEC[i].irq);
    end

    // R9: read data reflects the state before the capturing edge
    @(negedge clk);
    cfg_dw    = 6'h1C;
    cfg_wr    = 1'b1;
    cfg_be    = 4'h2;
    cfg_wdata = 32'h0000_3000;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R9 old value on write edge", cfg_rdata, 32'h0000_0800);
    @(posedge clk);
    @(negedge clk);
    check("R9 new value next edge", cfg_rdata, 32'h0000_3800);

    // R1: a second reset clears everything again
    do_reset();
    check_state("R1 re-reset", 2'b00, 2'b00, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule